// File: doc/BRIEF.md
# Seed Error Recovery Sequencer

This block is a small bus master that takes over the recovery of an entropy source after a seed error. It sits beside the entropy peripheral. When the peripheral raises its seed-error interrupt flag, or when a consumer reports that a data read returned zero, the sequencer runs the recovery on the peripheral's register bus. While it does so it holds the data consumers off through a busy output. When recovery succeeds it signals done. When recovery cannot be confirmed it raises a fatal error and keeps it.

Two recovery procedures are built in, and a mode input chooses between them. The conditioning-reset procedure first looks at the seed-error-current flag. If that flag is still set, the sequencer pulses the peripheral's conditioning-reset bit and then waits, under a timeout, for the reset to finish and for the error flags to clear. If the flag is already clear, the peripheral has reset itself, and the sequencer only has to clear the interrupt flag. The legacy procedure clears the interrupt flag, flushes the pipeline with a fixed number of discarded data reads, and then confirms that the flag has stayed clear.

The timeout is a cycle count. Its default equals 10 ms at the configured clock rate, and it can be reloaded through a configuration strobe.

Top module: `seedrec_seq`

## Requirements
- R1: In idle, a high `err_flag_i` or a high `zero_read_i` starts a sequence. `busy_o` goes high on the next cycle and stays high until the cycle in which `done_o` or `fatal_o` first appears. Every bus request is made while `busy_o` is high.
- R2: Each bus access holds `bus_req_o`, `bus_we_o`, `bus_addr_o` and `bus_wdata_o` steady until `bus_ack_i`. Read data is taken in the acknowledge cycle. The next access begins only after the previous one has been acknowledged.
- R3: In conditioning-reset mode (`mode_i`=1), the first access is a read of the status register (address 0x04). If that read shows seed-error-current (status bit 2) set, the sequencer reads the control register (0x00). It then writes that value with bit 30 set, and then writes the same value with bit 30 clear.
- R4: In conditioning-reset mode, if the first status read shows bit 2 clear, the only further access is one write to the status register with data 0xFFFFFFBF (bit 6 at zero clears the interrupt flag; ones leave the other bits alone). Done follows, and the control register is not written.
- R5: After the manual reset, the sequencer reads the control register until bit 30 reads 0. It then reads the status register. If bit 6 is set, it reports fatal. If bit 2 is still set, it reads the status register again. If both bits are clear, it reports done.
- R6: The timeout is loaded when the clearing control write is acknowledged. If, after the timeout has run out, a poll finds control bit 30 or status bit 2 still pending, the sequencer reports fatal.
- R7: The timeout limit resets to CLK_HZ/100 cycles. A cycle with `cfg_tmo_we_i` high loads `cfg_tmo_i` as the new limit.
- R8: In legacy mode (`mode_i`=0), the sequencer writes 0xFFFFFFBF to the status register. It then makes exactly 12 reads of the data register (0x08), and then reads the status register. If that read shows bit 6 set, it reports fatal; otherwise it reports done.
- R9: `done_o` is a single-cycle pulse at the end of a successful sequence. It is never high together with `busy_o` or `fatal_o`.
- R10: `fatal_o` stays high until reset. While it is high, `busy_o` is low, triggers are ignored, and no bus request is made.
- R11: After reset, `busy_o`, `done_o`, `fatal_o` and `bus_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 1 selects the conditioning-reset procedure, 0 selects the legacy flush procedure |
| err_flag_i | input | 1 | Seed-error interrupt flag seen at the peripheral |
| zero_read_i | input | 1 | A consumer data read returned zero |
| cfg_tmo_we_i | input | 1 | Load strobe for the timeout limit |
| cfg_tmo_i | input | TMO_W | New timeout limit in cycles |
| bus_req_o | output | 1 | Access request |
| bus_we_o | output | 1 | 1 for a write, 0 for a read |
| bus_addr_o | output | AW | Register address |
| bus_wdata_o | output | DW | Write data |
| bus_ack_i | input | 1 | Access acknowledge |
| bus_rdata_i | input | DW | Read data, valid with the acknowledge |
| busy_o | output | 1 | Recovery in progress; consumers must stall |
| done_o | output | 1 | One-cycle pulse when recovery succeeds |
| fatal_o | output | 1 | Sticky flag: recovery failed |

## Verification
The bench models the peripheral. Its conditioning reset can be held for a chosen time, its seed-error-current flag can lag behind the reset, and its interrupt flag can come back after the flush.

The runs are aimed at the following mistakes and what each would do:
- A wrong branch on the first status read would write the control register on an auto-reset, or would skip the reset pulse when the error is still current.
- A wrong discard count would show up as a number of data reads other than 12.
- Polls that never consult the timer would hang on a reset that never completes, where fatal is expected.
- Checking the flags in the wrong order would report done while the interrupt flag is still set.
- A fatal flag that is not sticky would let a later zero-read trigger start new bus traffic.

Wait states on the acknowledge check that an access never advances before its handshake completes.

// File: rtl/seedrec_pkg.sv
package seedrec_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SR_FIRST,
    ST_CR_READ,
    ST_CR_SET,
    ST_CR_CLR,
    ST_CR_POLL,
    ST_SR_POLL,
    ST_SR_CLR,
    ST_DISCARD,
    ST_SR_CONFIRM,
    ST_FATAL
  } seq_state_e;
endpackage

// File: rtl/seedrec_timer.sv
module seedrec_timer #(
  parameter int W       = 32,
  parameter int DEFAULT = 1000000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cfg_we_i,
  input  logic [W-1:0] cfg_val_i,
  input  logic         arm_i,
  input  logic         clr_i,
  output logic         expired_o
);
  logic [W-1:0] limit_q, cnt_q;
  logic         armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) limit_q <= W'(DEFAULT);
    else if (cfg_we_i) limit_q <= cfg_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
    end else if (arm_i) begin
      cnt_q   <= limit_q;
      armed_q <= 1'b1;
    end else if (armed_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = armed_q && (cnt_q == '0);

  AST_TMO_COUNTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && cnt_q != '0 && !arm_i && !clr_i |=> cnt_q == $past(cnt_q) - 1'b1); // R6
  AST_TMO_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o && !arm_i && !clr_i |=> expired_o); // R6
endmodule

// File: rtl/seedrec_bus.sv
module seedrec_bus #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  input  logic          ack_i,
  input  logic [DW-1:0] rdata_i,
  output logic          pend_o,
  output logic          rsp_vld_o,
  output logic [DW-1:0] rsp_data_o
);
  logic          req_q, we_q, rsp_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rsp_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q      <= 1'b0;
      we_q       <= 1'b0;
      rsp_q      <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      rsp_data_q <= '0;
    end else if (req_q && ack_i) begin
      req_q      <= 1'b0;
      rsp_q      <= 1'b1;
      rsp_data_q <= rdata_i;
    end else if (go_i && !req_q && !rsp_q) begin
      req_q   <= 1'b1;
      we_q    <= we_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
    end
  end

  assign req_o      = req_q;
  assign we_o       = we_q;
  assign addr_o     = addr_q;
  assign wdata_o    = wdata_q;
  assign pend_o     = req_q | rsp_q;
  assign rsp_vld_o  = rsp_q;
  assign rsp_data_o = rsp_data_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !ack_i |=> req_q && $stable(addr_q) && $stable(we_q) && $stable(wdata_q)); // R2
  AST_ONE_OUTSTANDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> !pend_o); // R2
  AST_RSP_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_q) |-> $past(req_q && ack_i)); // R2
endmodule

// File: rtl/seedrec_seq.sv
module seedrec_seq
  import seedrec_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          DW        = 32,
  parameter logic [7:0]  CTRL_ADDR = 8'h00,
  parameter logic [7:0]  STAT_ADDR = 8'h04,
  parameter logic [7:0]  DATA_ADDR = 8'h08,
  parameter int          RST_BIT   = 30,
  parameter int          SECS_BIT  = 2,
  parameter int          SEIS_BIT  = 6,
  parameter int          DISCARDS  = 12,
  parameter int          CLK_HZ    = 100000000,
  parameter int          TMO_W     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             err_flag_i,
  input  logic             zero_read_i,
  input  logic             cfg_tmo_we_i,
  input  logic [TMO_W-1:0] cfg_tmo_i,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [DW-1:0]    bus_wdata_o,
  input  logic             bus_ack_i,
  input  logic [DW-1:0]    bus_rdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fatal_o
);
  localparam int          TMO_DEFAULT = CLK_HZ / 100;
  localparam int          CNT_W       = $clog2(DISCARDS + 1);
  localparam logic [DW-1:0] RST_MASK  = DW'(1) << RST_BIT;
  localparam logic [DW-1:0] SECS_MASK = DW'(1) << SECS_BIT;
  localparam logic [DW-1:0] SEIS_MASK = DW'(1) << SEIS_BIT;

  seq_state_e    state_q;
  logic          mode_q, done_q;
  logic [DW-1:0] ctrl_q;
  logic [CNT_W-1:0] disc_q;

  logic          acc_go, acc_we, pend, rsp_vld, tmo_arm, tmo_clr, tmo_exp;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_wdata, rsp_data;
  logic          rsp_secs, rsp_seis, rsp_rst;

  assign rsp_secs = |(rsp_data & SECS_MASK);
  assign rsp_seis = |(rsp_data & SEIS_MASK);
  assign rsp_rst  = |(rsp_data & RST_MASK);

  always_comb begin
    acc_go    = 1'b0;
    acc_we    = 1'b0;
    acc_addr  = AW'(STAT_ADDR);
    acc_wdata = '0;
    case (state_q)
      ST_SR_FIRST, ST_SR_POLL, ST_SR_CONFIRM: acc_go = 1'b1;
      ST_CR_READ, ST_CR_POLL: begin
        acc_go   = 1'b1;
        acc_addr = AW'(CTRL_ADDR);
      end
      ST_CR_SET: begin
        acc_go    = 1'b1;
        acc_we    = 1'b1;
        acc_addr  = AW'(CTRL_ADDR);
        acc_wdata = ctrl_q | RST_MASK;
      end
      ST_CR_CLR: begin
        acc_go    = 1'b1;
        acc_we    = 1'b1;
        acc_addr  = AW'(CTRL_ADDR);
        acc_wdata = ctrl_q & ~RST_MASK;
      end
      ST_SR_CLR: begin
        acc_go    = 1'b1;
        acc_we    = 1'b1;
        acc_wdata = ~SEIS_MASK;
      end
      ST_DISCARD: begin
        acc_go   = 1'b1;
        acc_addr = AW'(DATA_ADDR);
      end
      default: ;
    endcase
    if (pend) acc_go = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
      ctrl_q  <= '0;
      disc_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (err_flag_i || zero_read_i) begin
          mode_q  <= mode_i;
          disc_q  <= '0;
          state_q <= mode_i ? ST_SR_FIRST : ST_SR_CLR;
        end
        ST_SR_FIRST: if (rsp_vld) state_q <= rsp_secs ? ST_CR_READ : ST_SR_CLR;
        ST_CR_READ: if (rsp_vld) begin
          ctrl_q  <= rsp_data;
          state_q <= ST_CR_SET;
        end
        ST_CR_SET: if (rsp_vld) state_q <= ST_CR_CLR;
        ST_CR_CLR: if (rsp_vld) state_q <= ST_CR_POLL;
        ST_CR_POLL: if (rsp_vld) begin
          if (!rsp_rst) state_q <= ST_SR_POLL;
          else if (tmo_exp) state_q <= ST_FATAL;
        end
        ST_SR_POLL: if (rsp_vld) begin
          if (rsp_seis) state_q <= ST_FATAL;
          else if (rsp_secs) begin
            if (tmo_exp) state_q <= ST_FATAL;
          end else begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_SR_CLR: if (rsp_vld) begin
          if (mode_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            state_q <= ST_DISCARD;
          end
        end
        ST_DISCARD: if (rsp_vld) begin
          if (disc_q == CNT_W'(DISCARDS - 1)) begin
            disc_q  <= '0;
            state_q <= ST_SR_CONFIRM;
          end else begin
            disc_q <= disc_q + 1'b1;
          end
        end
        ST_SR_CONFIRM: if (rsp_vld) begin
          if (rsp_seis) state_q <= ST_FATAL;
          else begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        ST_FATAL: state_q <= ST_FATAL;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tmo_arm = (state_q == ST_CR_CLR) && rsp_vld;
  assign tmo_clr = (state_q == ST_IDLE);

  seedrec_timer #(.W(TMO_W), .DEFAULT(TMO_DEFAULT)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (cfg_tmo_we_i),
    .cfg_val_i (cfg_tmo_i),
    .arm_i     (tmo_arm),
    .clr_i     (tmo_clr),
    .expired_o (tmo_exp)
  );

  seedrec_bus #(.AW(AW), .DW(DW)) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (acc_go),
    .we_i       (acc_we),
    .addr_i     (acc_addr),
    .wdata_i    (acc_wdata),
    .req_o      (bus_req_o),
    .we_o       (bus_we_o),
    .addr_o     (bus_addr_o),
    .wdata_o    (bus_wdata_o),
    .ack_i      (bus_ack_i),
    .rdata_i    (bus_rdata_i),
    .pend_o     (pend),
    .rsp_vld_o  (rsp_vld),
    .rsp_data_o (rsp_data)
  );

  assign busy_o  = (state_q != ST_IDLE) && (state_q != ST_FATAL);
  assign done_o  = done_q;
  assign fatal_o = (state_q == ST_FATAL);

  AST_REQ_IN_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o); // R1
  AST_START_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(err_flag_i || zero_read_i)); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !fatal_o); // R9
  AST_FATAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o && !busy_o); // R10
  AST_FATAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> !bus_req_o); // R10
endmodule

// File: tb/seedrec_seq_test.sv
module seedrec_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] RST_M  = 32'h4000_0000;
  localparam logic [31:0] SECS_M = 32'h0000_0004;
  localparam logic [31:0] SEIS_M = 32'h0000_0040;
  localparam logic [31:0] CLRW   = 32'hFFFF_FFBF;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b1;
  logic        zero_read_i = 1'b0;
  logic        cfg_tmo_we_i = 1'b0;
  logic [31:0] cfg_tmo_i = '0;
  logic        bus_req_o, bus_we_o, busy_o, done_o, fatal_o;
  logic [7:0]  bus_addr_o;
  logic [31:0] bus_wdata_o;
  logic        bus_ack_i = 1'b0;
  logic [31:0] bus_rdata_i = '0;
  logic        err_flag_i;

  // peripheral model state
  logic [31:0] m_ctrl, m_stat;
  int m_rst_hold, m_secs_hold, m_ack_dly, m_wait;
  bit m_seis_after, m_rearm, m_rst_run, m_secs_run;
  int m_data_reads;
  // access log
  logic        lg_we[64];
  logic [7:0]  lg_addr[64];
  logic [31:0] lg_data[64];
  int lg_n, n_ctrl_wr, n_data_rd, n_done, n_busy_viol;
  int checks = 0, errors = 0, cyc = 0;

  assign err_flag_i = m_stat[6];

  always #(CLK_PERIOD/2) clk = ~clk;

  seedrec_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .err_flag_i(err_flag_i),
    .zero_read_i(zero_read_i), .cfg_tmo_we_i(cfg_tmo_we_i), .cfg_tmo_i(cfg_tmo_i),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .fatal_o(fatal_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      if (bus_req_o && !busy_o) n_busy_viol++;
      if (done_o) n_done++;
      if (m_rst_run) begin
        if (m_rst_hold > 0) m_rst_hold--;
        else begin
          m_rst_run = 0;
          m_ctrl = m_ctrl & ~RST_M;
          if (m_seis_after) m_stat = m_stat | SEIS_M; else m_stat = m_stat & ~SEIS_M;
          m_secs_run = 1;
        end
      end else if (m_secs_run) begin
        if (m_secs_hold > 0) m_secs_hold--;
        else begin
          m_secs_run = 0;
          m_stat = m_stat & ~SECS_M;
        end
      end
    end
    if (bus_ack_i) bus_ack_i = 1'b0;
    else if (bus_req_o) begin
      if (m_wait < m_ack_dly) m_wait++;
      else begin
        m_wait = 0;
        bus_ack_i = 1'b1;
        if (lg_n < 64) begin
          lg_we[lg_n] = bus_we_o; lg_addr[lg_n] = bus_addr_o; lg_data[lg_n] = bus_wdata_o;
        end
        lg_n++;
        if (bus_we_o) begin
          if (bus_addr_o == 8'h00) begin
            n_ctrl_wr++;
            if (!bus_wdata_o[30] && m_ctrl[30]) begin
              m_ctrl = bus_wdata_o | RST_M;
              m_rst_run = 1;
            end else m_ctrl = bus_wdata_o;
          end else if (bus_addr_o == 8'h04) begin
            if (!bus_wdata_o[6]) m_stat = m_stat & ~SEIS_M;
          end
        end else begin
          case (bus_addr_o)
            8'h00: bus_rdata_i = m_ctrl;
            8'h04: bus_rdata_i = m_stat;
            default: begin
              n_data_rd++;
              m_data_reads++;
              bus_rdata_i = 32'h1234_5678 + m_data_reads;
              if (m_rearm && m_data_reads == 5) m_stat = m_stat | SEIS_M;
            end
          endcase
        end
      end
    end
  end

  task automatic do_reset(input logic [31:0] stat, input int ack_dly);
    rst_ni = 1'b0;
    m_ctrl = 32'h00F0_0D04; m_stat = stat;
    m_rst_hold = 4; m_secs_hold = 3; m_ack_dly = ack_dly; m_wait = 0;
    m_seis_after = 0; m_rearm = 0; m_rst_run = 0; m_secs_run = 0; m_data_reads = 0;
    lg_n = 0; n_ctrl_wr = 0; n_data_rd = 0; n_done = 0; n_busy_viol = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wait_end(input int max_cyc);
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge clk);
      if (done_o || fatal_o) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic program_tmo(input int v);
    @(negedge clk); cfg_tmo_i = v; cfg_tmo_we_i = 1'b1;
    @(negedge clk); cfg_tmo_we_i = 1'b0;
  endtask

  task automatic t_reset_state;
    do_reset(32'h0, 0);
    @(negedge clk);
    chk(!busy_o, "R11 busy", busy_o, 0);
    chk(!done_o, "R11 done", done_o, 0);
    chk(!fatal_o, "R11 fatal", fatal_o, 0);
    chk(!bus_req_o, "R11 req", bus_req_o, 0);
  endtask

  task automatic t_cond_manual;
    do_reset(32'h0, 2);
    mode_i = 1'b1;
    m_stat = SECS_M | SEIS_M;
    @(negedge clk);
    @(negedge clk);
    chk(busy_o, "R1 busy after trigger", busy_o, 1);
    wait_end(2000);
    chk(lg_addr[0] == 8'h04 && !lg_we[0], "R3 first access reads status", {lg_we[0], lg_addr[0]}, 32'h04);
    chk(lg_addr[1] == 8'h00 && !lg_we[1], "R3 control read", {lg_we[1], lg_addr[1]}, 32'h00);
    chk(lg_we[2] && lg_data[2] == 32'h40F0_0D04, "R3 reset bit set write", lg_data[2], 32'h40F0_0D04);
    chk(lg_we[3] && lg_data[3] == 32'h00F0_0D04, "R3 reset bit clear write", lg_data[3], 32'h00F0_0D04);
    chk(lg_addr[lg_n-1] == 8'h04 && !lg_we[lg_n-1], "R5 ends on status read", lg_addr[lg_n-1], 32'h04);
    chk(n_ctrl_wr == 2, "R5 no extra control writes", n_ctrl_wr, 2);
    chk(n_done == 1 && !fatal_o, "R9 single done pulse", n_done, 1);
    chk(!busy_o, "R1 busy drops", busy_o, 0);
    chk(n_busy_viol == 0, "R1 requests only while busy", n_busy_viol, 0);
  endtask

  task automatic t_cond_auto;
    do_reset(32'h0, 1);
    mode_i = 1'b1;
    m_stat = SEIS_M;
    wait_end(500);
    chk(lg_n == 2, "R4 two accesses", lg_n, 2);
    chk(lg_we[1] && lg_addr[1] == 8'h04 && lg_data[1] == CLRW, "R4 flag clear write", lg_data[1], CLRW);
    chk(n_ctrl_wr == 0, "R4 control untouched", n_ctrl_wr, 0);
    chk(n_done == 1 && !fatal_o, "R4 done", n_done, 1);
  endtask

  task automatic t_legacy_zero;
    do_reset(32'h0, 0);
    mode_i = 1'b0;
    @(negedge clk); zero_read_i = 1'b1;
    @(negedge clk); zero_read_i = 1'b0;
    wait_end(1000);
    chk(lg_we[0] && lg_addr[0] == 8'h04 && lg_data[0] == CLRW, "R8 first clears flag", lg_data[0], CLRW);
    chk(n_data_rd == 12, "R8 discard count", n_data_rd, 12);
    chk(lg_n == 14 && !lg_we[13] && lg_addr[13] == 8'h04, "R8 confirm read last", lg_n, 14);
    chk(n_done == 1 && !fatal_o, "R8 done", n_done, 1);
  endtask

  task automatic t_legacy_fatal;
    do_reset(32'h0, 3);
    mode_i = 1'b0;
    m_stat = SEIS_M;
    m_rearm = 1;
    wait_end(2000);
    chk(fatal_o, "R8 fatal on returned flag", fatal_o, 1);
    chk(n_done == 0, "R9 no done on failure", n_done, 0);
    chk(lg_n == 14, "R8 access count before fatal", lg_n, 14);
    @(negedge clk); zero_read_i = 1'b1;
    @(negedge clk); zero_read_i = 1'b0;
    repeat (50) @(negedge clk);
    chk(lg_n == 14, "R10 no traffic after fatal", lg_n, 14);
    chk(fatal_o && !busy_o, "R10 fatal sticky busy low", {busy_o, fatal_o}, 32'h1);
  endtask

  task automatic t_cond_seis_stuck;
    do_reset(32'h0, 0);
    mode_i = 1'b1;
    m_stat = SECS_M | SEIS_M;
    m_seis_after = 1;
    wait_end(2000);
    chk(fatal_o && n_done == 0, "R5 fatal when flag persists", fatal_o, 1);
  endtask

  task automatic t_tmo_reset_stuck;
    do_reset(32'h0, 0);
    program_tmo(40);
    mode_i = 1'b1;
    m_rst_hold = 100000;
    m_stat = SECS_M | SEIS_M;
    wait_end(400);
    chk(fatal_o, "R6 fatal on stuck reset bit", fatal_o, 1);
    chk(!lg_we[lg_n-1] && lg_addr[lg_n-1] == 8'h00, "R6 last poll on control", lg_addr[lg_n-1], 32'h00);
  endtask

  task automatic t_tmo_secs;
    do_reset(32'h0, 0);
    program_tmo(60);
    mode_i = 1'b1;
    m_secs_hold = 300;
    m_stat = SECS_M | SEIS_M;
    wait_end(1000);
    chk(fatal_o, "R7 short limit expires", fatal_o, 1);
    do_reset(32'h0, 0);
    program_tmo(600);
    mode_i = 1'b1;
    m_secs_hold = 150;
    m_stat = SECS_M | SEIS_M;
    wait_end(2000);
    chk(!fatal_o && n_done == 1, "R7 long limit succeeds", n_done, 1);
  endtask

  task automatic t_tmo_default;
    do_reset(32'h0, 0);
    mode_i = 1'b1;
    m_rst_hold = 3000;
    m_stat = SECS_M | SEIS_M;
    wait_end(8000);
    chk(!fatal_o && n_done == 1, "R7 default limit outlasts slow reset", n_done, 1);
  endtask

  initial begin
    t_reset_state();
    t_cond_manual();
    t_cond_auto();
    t_legacy_zero();
    t_legacy_fatal();
    t_cond_seis_stuck();
    t_tmo_reset_stuck();
    t_tmo_secs();
    t_tmo_default();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule